// File: doc/BRIEF.md
# Banked Dual Data Pointer Unit

This block keeps two independent 16-bit address pointers for an 8-bit microcontroller core, along with an auxiliary control register. Bit 0 of that register chooses which pointer is active. Software reaches the active pointer one byte at a time through a special-function-register (SFR) port. The core works on the same pointer through plain command strobes: increment it, load it with a 16-bit immediate, or present it as an address.

The address output is combinational. In direct mode it carries the active pointer and serves external data reads and writes. In indexed mode it carries the active pointer plus the 8-bit accumulator, for code-byte fetches and indirect jumps.

Every interface here is a one-cycle strobe or a combinational value. There is no valid/ready stream, so back-pressure never applies. A strobe takes effect at the next rising clock edge. Bit 2 of the control register is always zero. Because of that, a software read, add-one, write-back of the control register flips the select bit and leaves the flag bits above it alone.

Top module: `dual_ptr_unit`

## Requirements
- R1: After reset both pointers hold 0x0000 and the control register reads 0x00, so pointer 0 is selected.
- R2: The control register sits at SFR address 0xA2. Its bit 0 selects the active pointer: 0 selects pointer 0 and 1 selects pointer 1. Bits 7:3, 1 and 0 are read/write.
- R3: Bit 2 of the control register always reads 0, and writing a 1 to it has no effect.
- R4: A read of 0xA2, plus 1, written back to 0xA2, toggles bit 0 and leaves bits 7:3 unchanged.
- R5: SFR address 0x82 reads and writes bits 7:0 of the active pointer, and 0x83 reads and writes bits 15:8. The inactive pointer is never changed by these writes.
- R6: A `cmd_inc` strobe adds 1 to the active pointer, modulo 2^16, so 0xFFFF becomes 0x0000.
- R7: A `cmd_load` strobe writes `cmd_imm` into the active pointer only. When `cmd_load` and `cmd_inc` are both high, the load wins.
- R8: When a core strobe and an SFR pointer-byte write happen in the same cycle, the SFR byte write is discarded.
- R9: With `idx_mode` low, `addr_out` equals the active pointer. With it high, `addr_out` equals the active pointer plus the unsigned `acc`, modulo 2^16.
- R10: Any other SFR address reads 0x00, and writes to it change no pointer and no control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Combinational SFR read data |
| cmd_inc | input | 1 | Increment the active pointer |
| cmd_load | input | 1 | Load the active pointer from `cmd_imm` |
| cmd_imm | input | 16 | Immediate value for a load |
| acc | input | 8 | Accumulator offset for indexed mode |
| idx_mode | input | 1 | 1 adds `acc` to the address output |
| addr_out | output | 16 | Address presented to memory |

## Verification
Byte writes use different values in the low and high lanes, so a swapped lane or a write that reaches the inactive pointer is detected. Increments start from 0x00FF, 0x7FFF and 0xFFFF. These three values separate an 8-bit carry from a full 16-bit carry and check the wrap. The indexed address is tried on several pointers across a sweep of accumulator values, including sums that cross 0xFFFF, and this exposes a sign-extended or truncated offset. An eight-step read-add-write sequence on the control register, run with the flag bit both set and clear, shows whether bit 2 is masked. Same-cycle collisions show which source wins.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  parameter int PTR_W  = 16;
  parameter int DATA_W = 8;
  parameter int SFR_AW = 8;

  parameter logic [SFR_AW-1:0] A_PLO  = 8'h82;
  parameter logic [SFR_AW-1:0] A_PHI  = 8'h83;
  parameter logic [SFR_AW-1:0] A_CTRL = 8'hA2;

  parameter int SEL_BIT  = 0;
  parameter int ZERO_BIT = 2;

  typedef enum logic [1:0] {
    SFR_NONE,
    SFR_PLO,
    SFR_PHI,
    SFR_CTRL
  } sfr_tgt_e;
endpackage

// File: rtl/dptr_slot.sv
module dptr_slot #(
  parameter int PTR_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              cmd_inc,
  input  logic              cmd_load,
  input  logic [PTR_W-1:0]  cmd_imm,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [PTR_W-1:0]  val
);
  localparam int HI_W = PTR_W - DATA_W;
  localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val <= '0;
    end else if (active) begin
      if (cmd_load) begin
        val <= cmd_imm;
      end else if (cmd_inc) begin
        val <= val + ONE;
      end else begin
        if (wr_lo) val[DATA_W-1:0]     <= wdata;
        if (wr_hi) val[PTR_W-1:DATA_W] <= wdata[HI_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dptr_ctrl_reg.sv
module dptr_ctrl_reg #(
  parameter int DATA_W   = 8,
  parameter int SEL_BIT  = 0,
  parameter int ZERO_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q,
  output logic              sel
);
  localparam logic [DATA_W-1:0] WMASK = ~(DATA_W'(1) << ZERO_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= wdata & WMASK;
  end

  assign sel = q[SEL_BIT];
endmodule

// File: rtl/dptr_addr_gen.sv
module dptr_addr_gen #(
  parameter int PTR_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic [PTR_W-1:0]  ptr,
  input  logic [DATA_W-1:0] acc,
  input  logic              idx_mode,
  output logic [PTR_W-1:0]  addr
);
  logic [PTR_W-1:0] off;

  assign off  = idx_mode ? {{(PTR_W-DATA_W){1'b0}}, acc} : '0;
  assign addr = ptr + off;
endmodule

// File: rtl/dual_ptr_unit.sv
module dual_ptr_unit
  import dptr_pkg::*;
#(
  parameter int PW = PTR_W,
  parameter int DW = DATA_W,
  parameter int AW = SFR_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] sfr_addr,
  input  logic          sfr_wr,
  input  logic [DW-1:0] sfr_wdata,
  output logic [DW-1:0] sfr_rdata,
  input  logic          cmd_inc,
  input  logic          cmd_load,
  input  logic [PW-1:0] cmd_imm,
  input  logic [DW-1:0] acc,
  input  logic          idx_mode,
  output logic [PW-1:0] addr_out
);
  localparam int NSLOT = 2;
  localparam int HI_W  = PW - DW;

  sfr_tgt_e      tgt;
  logic [DW-1:0] ctrl_q;
  logic          sel_q;
  logic [PW-1:0] ptr_val [NSLOT];
  logic [PW-1:0] act_ptr;

  always_comb begin
    unique case (sfr_addr)
      A_PLO:   tgt = SFR_PLO;
      A_PHI:   tgt = SFR_PHI;
      A_CTRL:  tgt = SFR_CTRL;
      default: tgt = SFR_NONE;
    endcase
  end

  dptr_ctrl_reg #(.DATA_W(DW), .SEL_BIT(SEL_BIT), .ZERO_BIT(ZERO_BIT)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (sfr_wr && (tgt == SFR_CTRL)),
    .wdata (sfr_wdata),
    .q     (ctrl_q),
    .sel   (sel_q)
  );

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    dptr_slot #(.PTR_W(PW), .DATA_W(DW)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (sel_q == 1'(i)),
      .cmd_inc  (cmd_inc),
      .cmd_load (cmd_load),
      .cmd_imm  (cmd_imm),
      .wr_lo    (sfr_wr && (tgt == SFR_PLO)),
      .wr_hi    (sfr_wr && (tgt == SFR_PHI)),
      .wdata    (sfr_wdata),
      .val      (ptr_val[i])
    );
  end

  assign act_ptr = ptr_val[sel_q];

  dptr_addr_gen #(.PTR_W(PW), .DATA_W(DW)) u_agen (
    .ptr      (act_ptr),
    .acc      (acc),
    .idx_mode (idx_mode),
    .addr     (addr_out)
  );

  always_comb begin
    sfr_rdata = '0;
    case (tgt)
      SFR_PLO:  sfr_rdata = act_ptr[DW-1:0];
      SFR_PHI:  sfr_rdata[HI_W-1:0] = act_ptr[PW-1:DW];
      SFR_CTRL: sfr_rdata = ctrl_q;
      default:  sfr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_ptr_unit_chk.sv
module dual_ptr_unit_chk #(
  parameter int PW = 16,
  parameter int DW = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic [PW-1:0] p0,
  input logic [PW-1:0] p1,
  input logic          cmd_inc,
  input logic          cmd_load,
  input logic [PW-1:0] cmd_imm,
  input logic [AW-1:0] sfr_addr,
  input logic [DW-1:0] sfr_rdata,
  input logic          idx_mode,
  input logic [PW-1:0] addr_out
);
  localparam logic [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

  // R3
  zero_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == 8'hA2) |-> (sfr_rdata[2] == 1'b0));

  // R5
  idle_p1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(p1));

  // R5
  idle_p0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel |=> $stable(p0));

  // R7
  load_p0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_load && !sel) |=> (p0 == $past(cmd_imm)));

  // R7
  load_p1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_load && sel) |=> (p1 == $past(cmd_imm)));

  // R6
  inc_p0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_inc && !cmd_load && !sel) |=> (p0 == $past(p0) + ONE));

  // R9
  direct_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_mode |-> (addr_out == (sel ? p1 : p0)));
endmodule

bind dual_ptr_unit dual_ptr_unit_chk #(.PW(PW), .DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel       (sel_q),
  .p0        (ptr_val[0]),
  .p1        (ptr_val[1]),
  .cmd_inc   (cmd_inc),
  .cmd_load  (cmd_load),
  .cmd_imm   (cmd_imm),
  .sfr_addr  (sfr_addr),
  .sfr_rdata (sfr_rdata),
  .idx_mode  (idx_mode),
  .addr_out  (addr_out)
);

// File: tb/sim_dual_ptr_unit.sv
`timescale 1ns/1ps
module sim_dual_ptr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic        sfr_wr = 1'b0;
  logic [7:0]  sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic        cmd_inc = 1'b0;
  logic        cmd_load = 1'b0;
  logic [15:0] cmd_imm = 16'h0000;
  logic [7:0]  acc = 8'h00;
  logic        idx_mode = 1'b0;
  logic [15:0] addr_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_ptr_unit u0 (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .cmd_inc(cmd_inc),
    .cmd_load(cmd_load), .cmd_imm(cmd_imm), .acc(acc), .idx_mode(idx_mode),
    .addr_out(addr_out)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    sfr_wr = 1'b0; cmd_inc = 1'b0; cmd_load = 1'b0;
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    step();
  endtask

  task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    sfr_addr = a;
    #1 d = sfr_rdata;
  endtask

  task automatic read_ptr(output logic [15:0] v);
    logic [7:0] lo, hi;
    sfr_read(8'h82, lo);
    sfr_read(8'h83, hi);
    v = {hi, lo};
  endtask

  task automatic load(input logic [15:0] v);
    @(negedge clk);
    cmd_imm = v; cmd_load = 1'b1;
    step();
  endtask

  task automatic inc();
    @(negedge clk);
    cmd_inc = 1'b1;
    step();
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0]  r;
    logic [15:0] v;
    logic [7:0]  m;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    sfr_read(8'hA2, r); check("R1 ctrl", {8'h0, r}, 16'h0000);
    read_ptr(v);        check("R1 ptr0", v, 16'h0000);
    sfr_write(8'hA2, 8'h01);
    read_ptr(v);        check("R1 ptr1", v, 16'h0000);
    sfr_write(8'hA2, 8'h00);

    // R5 / R2 byte lanes and bank isolation
    sfr_write(8'h82, 8'h3C); sfr_write(8'h83, 8'hA5);
    read_ptr(v); check("R5 ptr0 bytes", v, 16'hA53C);
    sfr_write(8'hA2, 8'h01);
    sfr_read(8'hA2, r); check("R2 sel readback", {8'h0, r}, 16'h0001);
    read_ptr(v); check("R5 ptr1 untouched", v, 16'h0000);
    sfr_write(8'h82, 8'hC3); sfr_write(8'h83, 8'h5A);
    read_ptr(v); check("R5 ptr1 bytes", v, 16'h5AC3);
    sfr_write(8'hA2, 8'h00);
    read_ptr(v); check("R2 ptr0 kept", v, 16'hA53C);
    #1 check("R9 direct ptr0", addr_out, 16'hA53C);

    // R3 bit 2 masked
    sfr_write(8'hA2, 8'hFF);
    sfr_read(8'hA2, r); check("R3 write ones", {8'h0, r}, 16'h00FB);
    sfr_write(8'hA2, 8'h04);
    sfr_read(8'hA2, r); check("R3 bit2 only", {8'h0, r}, 16'h0000);

    // R4 read-add-write sequence, flag set then clear
    for (int f = 0; f < 2; f++) begin
      m = f ? 8'h08 : 8'hF0;
      sfr_write(8'hA2, m);
      for (int k = 0; k < 8; k++) begin
        logic [7:0] nm;
        sfr_read(8'hA2, r);
        sfr_write(8'hA2, r + 8'h01);
        nm = (m + 8'h01) & 8'hFB;
        sfr_read(8'hA2, r);
        check("R4 value", {8'h0, r}, {8'h0, nm});
        check("R4 toggle", {15'h0, r[0]}, {15'h0, ~m[0]});
        check("R4 upper kept", {11'h0, r[7:3]}, {11'h0, m[7:3]});
        m = nm;
      end
    end
    sfr_write(8'hA2, 8'h00);

    // R6 increments with carry chains and wrap
    load(16'h00FF); inc(); read_ptr(v); check("R6 byte carry", v, 16'h0100);
    load(16'h7FFF); inc(); read_ptr(v); check("R6 mid carry", v, 16'h8000);
    load(16'hFFFF); inc(); read_ptr(v); check("R6 wrap", v, 16'h0000);
    sfr_write(8'hA2, 8'h01);
    read_ptr(v); check("R6 ptr1 untouched", v, 16'h5AC3);
    inc(); read_ptr(v); check("R6 ptr1 inc", v, 16'h5AC4);

    // R7 load into ptr1 only; load beats inc
    load(16'h1357); read_ptr(v); check("R7 load ptr1", v, 16'h1357);
    @(negedge clk); cmd_imm = 16'h2468; cmd_load = 1'b1; cmd_inc = 1'b1; step();
    read_ptr(v); check("R7 load over inc", v, 16'h2468);
    sfr_write(8'hA2, 8'h00);
    read_ptr(v); check("R7 ptr0 untouched", v, 16'h0000);

    // R8 core command beats SFR byte write
    load(16'h10FF);
    @(negedge clk); sfr_addr = 8'h82; sfr_wdata = 8'h55; sfr_wr = 1'b1; cmd_inc = 1'b1; step();
    read_ptr(v); check("R8 inc over write", v, 16'h1100);
    @(negedge clk); sfr_addr = 8'h83; sfr_wdata = 8'h66; sfr_wr = 1'b1;
    cmd_load = 1'b1; cmd_imm = 16'hBEEF; step();
    read_ptr(v); check("R8 load over write", v, 16'hBEEF);

    // R10 unmapped address
    sfr_write(8'h81, 8'hFF); sfr_write(8'hA3, 8'hFF);
    sfr_read(8'h81, r); check("R10 read zero", {8'h0, r}, 16'h0000);
    read_ptr(v); check("R10 ptr kept", v, 16'hBEEF);
    sfr_read(8'hA2, r); check("R10 ctrl kept", {8'h0, r}, 16'h0000);

    // R9 indexed sweep on both pointers
    for (int s = 0; s < 2; s++) begin
      sfr_write(8'hA2, 8'(s));
      for (int pi = 0; pi < 4; pi++) begin
        logic [15:0] pv;
        case (pi)
          0: pv = 16'h0000;
          1: pv = 16'h1234;
          2: pv = 16'hFF80;
          default: pv = 16'hFFFF;
        endcase
        pv = pv ^ 16'(s * 16'h0101);
        load(pv);
        for (int a = 0; a < 256; a += 15) begin
          @(negedge clk); acc = 8'(a); idx_mode = 1'b1;
          #1 check("R9 indexed", addr_out, pv + 16'(a));
          idx_mode = 1'b0;
          #1 check("R9 direct", addr_out, pv);
        end
      end
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule